// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a pipelined synchronous static RAM whose bus can switch between reads and writes without idle cycles. Every enabled rising clock edge samples a combined chip enable, a load/advance control, a write enable, per-lane byte write selects and an address. From these it decides the kind of cycle: deselect, read, dummy read, write, write abort, stall or sleep. Read data leaves through an output register. Write data is taken from the bus a fixed number of enabled edges after its address. The array is a small register memory inside the block.

A load cycle starts an access at the supplied address. Advance cycles then step through a four-word group, either counting up with wrap-around or stepping by XOR, as a mode pin selects. A separate output enable gates the bus drivers directly, without a clock. A clock enable freezes the whole block. A sleep input switches the bus off and discards every access still in flight.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no read issued, `dq_oe` is 0 even with `oe_n` low.
- R2: A read loaded at enabled edge N (`ce_n`=0, `adv_ld`=0, `we_n`=1) drives the stored word on `dq_out` with `dq_oe`=1 from just after enabled edge N+1 until enabled edge N+2.
- R3: A load with `ce_n`=1 is a deselect, and the bus stays off. Advance cycles after a deselect continue the deselect whatever `ce_n` and `we_n` are.
- R4: An advance cycle (`adv_ld`=1) after a read or write load accesses the next address of the burst. Address bits above bit 1 are held. With `lin_mode`=1 the low two bits are the start value plus the advance count, modulo 4. With `lin_mode`=0 they are the start value XOR the count.
- R5: A read whose output window sees `oe_n`=1 is a dummy read: the bus stays off, but the burst address still advances.
- R6: A write loaded or advanced at enabled edge N takes `dq_in` at enabled edge N+2. Lane i (bits 8i+7..8i) is written only when `bw_n[i]`=0 in the address cycle. Other lanes keep their value.
- R7: A write cycle with all `bw_n` bits 1 is a write abort: no byte of the array changes.
- R8: In the data window of a write, `dq_oe` is 0 even with `oe_n` low.
- R9: `oe_n` acts without a clock: inside a read window, `dq_oe` follows `oe_n` within the same cycle.
- R10: While `cen_n`=1 the edge is ignored. Outputs, burst state and array hold their values, and the other inputs have no effect.
- R11: `sleep`=1 switches the bus off at once and drops all accesses in flight. After wake-up the bus stays off until a new read reaches its window.
- R12: A read issued in the cycle right after a write to the same address returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep request, active high |
| cen_n | input | 1 | Clock enable, active low (high stalls) |
| ce_n | input | 1 | Combined chip enable, active low |
| adv_ld | input | 1 | 0 = load new access, 1 = advance burst |
| we_n | input | 1 | Write enable for load cycles, active low |
| bw_n | input | LANES | Per-lane byte write selects, active low |
| addr | input | ADDR_W | Word address for load cycles |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench uses the default build: a 5-bit address (32 words) and four 8-bit lanes. The array is then large enough to place bursts starting in the middle of a quartet, so both linear and XOR ordering wrap within the group. The partial-lane pattern touches each of the four lanes in both states. Back-to-back read/write mixes, stalls inside a write's data window, and sleep entered during a live read window are all reachable at this size.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sleep,
  input  logic                      cen_n,
  input  logic                      ce_n,
  input  logic                      adv_ld,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      lin_mode,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_RD   = 2'd1;
  localparam logic [1:0] K_WR   = 2'd2;

  logic [DW-1:0]     mem [DEPTH];
  logic [1:0]        bst, nbst;
  logic [ADDR_W-1:0] base, nbase, ea;
  logic [1:0]        cnt, ncnt;
  logic [1:0]        op1, op2;
  logic [ADDR_W-1:0] a1, a2;
  logic [LANES-1:0]  be1, be2;
  logic [DW-1:0]     rd_word, dout;
  logic              rd_ph;
  logic              go;

  assign go = !cen_n && !sleep;

  always_comb begin
    nbst  = bst;
    nbase = base;
    ncnt  = cnt;
    if (!adv_ld) begin
      ncnt = 2'd0;
      if (ce_n) nbst = K_NONE;
      else begin
        nbase = addr;
        nbst  = we_n ? K_RD : K_WR;
      end
    end else if (bst != K_NONE) begin
      ncnt = cnt + 2'd1;
    end
    ea = nbase;
    ea[1:0] = lin_mode ? (nbase[1:0] + ncnt) : (nbase[1:0] ^ ncnt);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_word[l*LANE_W +: LANE_W] =
      (op2 == K_WR && be2[l] && a2 == a1) ? dq_in[l*LANE_W +: LANE_W]
                                          : mem[a1][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (go && op2 == K_WR) begin
      for (int l = 0; l < LANES; l++)
        if (be2[l]) mem[a2][l*LANE_W +: LANE_W] <= dq_in[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst <= K_NONE; base <= '0; cnt <= '0;
      op1 <= K_NONE; op2 <= K_NONE; a1 <= '0; a2 <= '0;
      be1 <= '0; be2 <= '0; dout <= '0; rd_ph <= 1'b0;
    end else if (sleep) begin
      bst <= K_NONE; cnt <= '0;
      op1 <= K_NONE; op2 <= K_NONE; be1 <= '0; be2 <= '0;
      rd_ph <= 1'b0;
    end else if (!cen_n) begin
      bst  <= nbst;
      base <= nbase;
      cnt  <= ncnt;
      op1  <= nbst;
      a1   <= ea;
      be1  <= (nbst == K_WR) ? ~bw_n : '0;
      op2  <= op1;
      a2   <= a1;
      be2  <= be1;
      rd_ph <= (op1 == K_RD);
      if (op1 == K_RD) dout <= rd_word;
    end
  end

  assign dq_out = dout;
  assign dq_oe  = rd_ph && !oe_n && !sleep;

  p_sleep_tri_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  p_write_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op2 == K_WR) |-> !dq_oe);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !sleep) |=> $stable(dq_out));
  p_burst_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_ld && bst != K_NONE) |=> (a1[ADDR_W-1:2] == $past(a1[ADDR_W-1:2])));
endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;
  logic clk = 0, rst_n = 0, sleep = 0, cen_n = 0, ce_n = 1, adv_ld = 0, we_n = 1;
  logic [3:0] bw_n = 4'hF;
  logic [4:0] addr = '0;
  logic lin_mode = 1, oe_n = 0;
  logic [31:0] dq_in = '0, dq_out;
  logic dq_oe;

  sram_cycle_ctrl dut (.clk(clk), .rst_n(rst_n), .sleep(sleep), .cen_n(cen_n),
    .ce_n(ce_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .lin_mode(lin_mode), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  always #5 clk = ~clk;

  typedef struct { int due; bit rd; logic [31:0] data; string tag; } exp_t;
  exp_t q[$];
  int nchk = 0, nerr = 0, ecnt = 0;
  bit run = 0, done = 0;
  logic [31:0] model [32];
  logic [1:0] bst = 0, cnt = 0;
  logic [4:0] base = 0;
  logic [31:0] wp0 = 0, wp1 = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      while (q.size() > 0 && q[0].due <= ecnt) begin
        exp_t e;
        bit want;
        e = q.pop_front();
        want = e.rd && !oe_n;
        chk(dq_oe == want, {e.tag, " bus enable"}, {31'd0, dq_oe}, {31'd0, want});
        if (want) chk(dq_out == e.data, {e.tag, " data"}, dq_out, e.data);
      end
    end
  end

  task automatic step(input logic c, input logic v, input logic w, input logic [3:0] b,
                      input logic [4:0] a, input logic [31:0] d, input string tag);
    logic [4:0] ea;
    bit isrd;
    logic [31:0] rdv;
    isrd = 0; rdv = '0;
    ce_n = c; adv_ld = v; we_n = w; bw_n = b; addr = a; dq_in = wp1; cen_n = 0;
    if (!v) begin
      cnt = 0;
      if (c) bst = 0;
      else begin base = a; bst = w ? 2'd1 : 2'd2; end
    end else if (bst != 0) cnt = cnt + 2'd1;
    ea = base;
    ea[1:0] = lin_mode ? (base[1:0] + cnt) : (base[1:0] ^ cnt);
    if (bst == 2)
      for (int l = 0; l < 4; l++) if (!b[l]) model[ea][l*8 +: 8] = d[l*8 +: 8];
    if (bst == 1) begin isrd = 1; rdv = model[ea]; end
    @(posedge clk);
    ecnt++;
    q.push_back('{due: ecnt + 1, rd: isrd, data: rdv, tag: tag});
    wp1 = wp0;
    wp0 = (bst == 2) ? d : (32'hDEAD0000 ^ ecnt);
    #1;
  endtask

  task automatic rd(input logic [4:0] a, input string tag); step(0, 0, 1, 4'hF, a, 0, tag); endtask
  task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d, input string tag);
    step(0, 0, 0, b, a, d, tag);
  endtask
  task automatic adv(input logic [3:0] b, input logic [31:0] d, input string tag); step(1, 1, 1, b, 5'd31, d, tag); endtask
  task automatic nop(input string tag); step(1, 0, 1, 4'hF, 0, 0, tag); endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 'x;
    repeat (3) @(posedge clk);
    #2 chk(dq_oe == 0, "R1 in reset", {31'd0, dq_oe}, 0);
    @(posedge clk); #1 rst_n = 1;
    run = 1;
    nop("R1"); nop("R1");
    chk(dq_oe == 0, "R1 after reset", {31'd0, dq_oe}, 0);

    wr(3, 4'h0, 32'h11223344, "R6");
    wr(4, 4'h0, 32'h55667788, "R8");
    rd(3, "R2"); rd(4, "R2");
    nop("R3"); nop("R3");
    wr(3, 4'b1010, 32'hAABBCCDD, "R6");
    nop("R6"); rd(3, "R6");
    wr(4, 4'hF, 32'hFFFFFFFF, "R7");
    nop("R7"); rd(4, "R7");
    wr(5, 4'h0, 32'h0BADF00D, "R12"); rd(5, "R12");
    rd(5, "R8"); wr(5, 4'b0110, 32'h12345678, "R8"); rd(5, "R12"); wr(6, 4'h0, 32'hCAFE0006, "R8"); rd(6, "R12");
    nop("R3");

    lin_mode = 1;
    wr(10, 4'h0, 32'hA0A0A00A, "R4"); adv(4'h0, 32'hA0A0A00B, "R4");
    adv(4'h0, 32'hA0A0A008, "R4"); adv(4'h0, 32'hA0A0A009, "R4");
    nop("R3");
    rd(9, "R4"); adv(4'hF, 0, "R4"); adv(4'hF, 0, "R4"); adv(4'hF, 0, "R4");
    lin_mode = 0;
    rd(9, "R4"); adv(4'hF, 0, "R4"); adv(4'hF, 0, "R4"); adv(4'hF, 0, "R4");
    wr(14, 4'h0, 32'h0E0E0E0E, "R4"); adv(4'b1100, 32'h0F0F0F0F, "R4"); nop("R4");
    rd(15, "R4");
    lin_mode = 1;

    nop("R3"); step(0, 1, 1, 4'hF, 9, 0, "R3"); step(0, 1, 0, 4'h0, 9, 0, "R3"); rd(9, "R3");
    nop("R3"); nop("R3");

    oe_n = 1;
    rd(8, "R5"); adv(4'hF, 0, "R5"); adv(4'hF, 0, "R5"); adv(4'hF, 0, "R5");
    oe_n = 0;
    nop("R5"); nop("R5");

    rd(3, "R9"); nop("R9");
    oe_n = 1; #1 chk(dq_oe == 0, "R9 oe off", {31'd0, dq_oe}, 0);
    oe_n = 0; #1 chk(dq_oe == 1 && dq_out == model[3], "R9 oe on", dq_out, model[3]);

    nop("R10");
    rd(4, "R10"); nop("R10");
    begin
      logic [31:0] hold_d;
      logic hold_e;
      hold_d = dq_out; hold_e = dq_oe;
      cen_n = 1; ce_n = 0; adv_ld = 0; we_n = 0; bw_n = 4'h0; addr = 4; dq_in = 32'h77777777;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #2;
        chk(dq_out == hold_d && dq_oe == hold_e, "R10 stall hold", dq_out, hold_d);
      end
      cen_n = 0;
    end
    nop("R10"); nop("R10"); rd(4, "R10");
    wr(7, 4'h0, 32'h70707070, "R10");
    cen_n = 1; dq_in = 32'h99999999;
    repeat (2) @(posedge clk);
    #1 cen_n = 0;
    nop("R10"); nop("R10"); rd(7, "R10"); nop("R10"); nop("R10");

    rd(6, "R11"); nop("R11");
    sleep = 1; #1 chk(dq_oe == 0, "R11 sleep now", {31'd0, dq_oe}, 0);
    q.delete();
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #2 chk(dq_oe == 0, "R11 asleep", {31'd0, dq_oe}, 0);
    end
    sleep = 0; bst = 0; cnt = 0;
    nop("R11"); nop("R11"); nop("R11");
    rd(6, "R11"); nop("R11"); nop("R11");

    run = 0; done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule